// File: doc/BRIEF.md
# Password-Gated Watchdog Reset Controller

This block is a small register-mapped watchdog that can pull a full-chip reset. Software talks to it through a plain valid/write/address/data port that exposes three 32-bit registers: a control register holding a two-bit reset-type field, a status register that keeps reset cause and boot-partition hints, and a timeout register holding a 20-bit down-counter. A write is accepted only when its top byte carries the unlock code 0x5A. Writes without the code are dropped.

Once the reset-type field selects a full reset, every pulse on the tick-enable input takes one off the counter. The tick runs at 65536 per second, so one second is a count of 1 << 16. When the count runs out, the block raises its reset-request output for a fixed number of clocks. It also marks the full-reset cause in the status register and clears the reset-type field, so the watchdog comes back disarmed. The block's own reset-request does not touch the status register. Partition hints written by software therefore survive the reset they trigger. Only the power-on reset input clears them.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: After power-on reset, reads of the control (0x1C), status (0x20) and timeout (0x24) registers all return 0, and `reset_req` is low.
- R2: A write whose data bits 31:24 differ from 0x5A changes no register.
- R3: Read data bits 31:24 are always 0. The control register reads its reset-type field in bits 5:4. The timeout register reads the remaining count in bits 19:0.
- R4: While bit 5 of the control register is 1, each `tick_en` pulse lowers a non-zero count by one. While bit 5 is 0, ticks leave the count unchanged.
- R5: With the reset-type field at 2'b10, a tick that finds the count at 1 or 0 starts a `reset_req` pulse on the next cycle. The pulse lasts exactly RST_PULSE clocks (default 16). The same tick clears the reset-type field to 2'b00.
- R6: Writing 0x5A000102 to the control register clears the reset-type field and freezes the count, and no reset request follows.
- R7: With the reset-type field at 2'b11, the count runs down to 0 and stays there, and no reset request is made.
- R8: An accepted timeout write loads bits 19:0 at once. It wins over a tick in the same cycle, and it wins over an expiry in that same cycle.
- R9: Software writes status bits 11:0 (partition bits 0, 2, 4, 6, 8 and 10, where 0x555 means halt). An expiry sets status bit 5 and leaves the other bits as they are, so 0x555 becomes 0x575.
- R10: The power-on reset input clears the status register, including the partition bits.
- R11: Writes to any other offset are ignored, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears every register |
| tick_en | input | 1 | Single-cycle countdown tick enable |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, unlock code in bits 31:24 |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| reset_req | output | 1 | Full-chip reset request pulse |

## Verification
The bench targets the countdown edges:
- It loads a 10-tick timeout and counts the ticks up to the request. A design that expired one tick early or late would move the pulse start.
- It counts the pulse width exactly. A design with an off-by-one stretch counter would give a pulse one clock too long or too short.

It also checks the status cause bit against the 0x555 halt hint. A design that overwrote the hint instead of OR-ing in the cause bit would lose the partition.

Same-cycle collisions are covered: a reload together with a tick, and a reload together with an expiring tick. A design with the wrong priority would show the decremented value, or would fire a reset despite the keepalive.

Finally, the bench checks the non-full reset-type code. A design that treated any set bit 5 as armed would fire a reset there.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 20;
    localparam int STAT_W   = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_TMO  = 8'h24;
    localparam logic [7:0]        UNLOCK   = 8'h5A;

    localparam logic [1:0] CFG_OFF  = 2'b00;
    localparam logic [1:0] CFG_FULL = 2'b10;
    localparam int         CAUSE_BIT = 5;

    typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_TMO} sel_e;

    typedef struct packed {
        logic [1:0]        cfg;
        logic [STAT_W-1:0] stat;
    } ctl_t;
endpackage

// File: rtl/wdr_decode.sv
module wdr_decode
    import wdr_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        key_byte,
    output sel_e              sel,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              wr_tmo
);
    logic accept;

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: sel = SEL_CTRL;
            OFS_STAT: sel = SEL_STAT;
            OFS_TMO:  sel = SEL_TMO;
            default:  sel = SEL_NONE;
        endcase
        accept  = bus_valid && bus_write && (key_byte == UNLOCK);
        wr_ctrl = accept && (sel == SEL_CTRL);
        wr_stat = accept && (sel == SEL_STAT);
        wr_tmo  = accept && (sel == SEL_TMO);
    end
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown
    import wdr_pkg::*;
#(
    parameter int W = CNT_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         armed,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d   = cd_q;
        expire = 1'b0;
        if (load) begin
            cd_d.cnt = load_val;
        end else begin
            if (run && tick && (cd_q.cnt != '0))
                cd_d.cnt = cd_q.cnt - 1'b1;
            expire = armed && tick && (cd_q.cnt <= W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign cnt = cd_q.cnt;
endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
    parameter int LEN = 16
)(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int PW = $clog2(LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pl_t;

    pl_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (fire)
            pl_d.left = PW'(LEN);
        else if (pl_q.left != '0)
            pl_d.left = pl_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    assign active = (pl_q.left != '0);
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl
    import wdr_pkg::*;
#(
    parameter int RST_PULSE = 16
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        reset_req
);
    sel_e             sel;
    logic             wr_ctrl, wr_stat, wr_tmo;
    logic             expire;
    logic [CNT_W-1:0] tmo_cnt;
    ctl_t             ctl_d, ctl_q;
    logic [1:0]       cfg_now;
    logic [STAT_W-1:0] stat_now;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[23:20];

    wdr_decode u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .key_byte  (bus_wdata[31:24]),
        .sel       (sel),
        .wr_ctrl   (wr_ctrl),
        .wr_stat   (wr_stat),
        .wr_tmo    (wr_tmo)
    );

    wdr_countdown #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .run      (ctl_q.cfg[1]),
        .armed    (ctl_q.cfg == CFG_FULL),
        .load     (wr_tmo),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (tmo_cnt),
        .expire   (expire)
    );

    wdr_pulse #(.LEN(RST_PULSE)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (expire),
        .active (reset_req)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (expire) begin
            ctl_d.cfg             = CFG_OFF;
            ctl_d.stat[CAUSE_BIT] = 1'b1;
        end
        if (wr_ctrl) ctl_d.cfg  = bus_wdata[5:4];
        if (wr_stat) ctl_d.stat = bus_wdata[STAT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cfg_now  = ctl_q.cfg;
    assign stat_now = ctl_q.stat;

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (sel)
                SEL_CTRL: bus_rdata[5:4]          = ctl_q.cfg;
                SEL_STAT: bus_rdata[STAT_W-1:0]   = ctl_q.stat;
                SEL_TMO:  bus_rdata[CNT_W-1:0]    = tmo_cnt;
                default:  bus_rdata               = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdr_checker.sv
module wdr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        reset_req,
    input logic [1:0]  cfg,
    input logic [11:0] stat,
    input logic [19:0] cnt
);
    logic tmo_good_wr, tmo_any_wr, bad_key_wr;
    assign tmo_good_wr = bus_valid && bus_write && bus_addr == 8'h24 && bus_wdata[31:24] == 8'h5A;
    assign tmo_any_wr  = bus_valid && bus_write && bus_addr == 8'h24;
    assign bad_key_wr  = bus_valid && bus_write && bus_wdata[31:24] != 8'h5A;

    AST_KEY_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:24] == 8'h00); // R3

    AST_BAD_KEY_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_key_wr && !reset_req && cfg != 2'b10) |=> $stable(stat)); // R2

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_good_wr |=> cnt == $past(bus_wdata[19:0])); // R8

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[1] && !tmo_any_wr) |=> $stable(cnt)); // R4

    AST_NO_SPURIOUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != 2'b10 && !reset_req) |=> !reset_req); // R7

    AST_CAUSE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> stat[5]); // R9

    AST_DISARM_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reset_req) && !$past(bus_valid && bus_write && bus_addr == 8'h1C)) |-> cfg == 2'b00); // R5
endmodule

bind wdog_rst_ctrl wdr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .reset_req (reset_req),
    .cfg       (cfg_now),
    .stat      (stat_now),
    .cnt       (tmo_cnt)
);

// File: tb/wdog_rst_ctrl_test.sv
`timescale 1ns/1ps
module wdog_rst_ctrl_test;
    localparam int PULSE = 16;
    localparam logic [7:0] A_CTRL = 8'h1C, A_STAT = 8'h20, A_TMO = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdog_rst_ctrl #(.RST_PULSE(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 8'h1C, 32'h0},          // R1
        '{1'b1, 8'h20, 32'h0},          // R1
        '{1'b1, 8'h24, 32'h0},          // R1
        '{1'b0, 8'h24, 32'h0000_0123},  // R2 no key
        '{1'b1, 8'h24, 32'h0},          // R2
        '{1'b0, 8'h24, 32'h5A00_0123},
        '{1'b1, 8'h24, 32'h0000_0123},  // R3 key byte reads 0
        '{1'b0, 8'h20, 32'hA500_0555},  // R2 wrong key
        '{1'b1, 8'h20, 32'h0},
        '{1'b0, 8'h20, 32'h5A00_0555},
        '{1'b1, 8'h20, 32'h0000_0555},  // R9
        '{1'b0, 8'h1C, 32'h5A00_0030},
        '{1'b1, 8'h1C, 32'h0000_0030},  // R3
        '{1'b0, 8'h1C, 32'h5A00_0102},
        '{1'b1, 8'h1C, 32'h0},          // R6
        '{1'b0, 8'h40, 32'h5A00_00FF},
        '{1'b1, 8'h40, 32'h0},          // R11
        '{1'b0, 8'h1C, 32'h5B00_0020},
        '{1'b1, 8'h1C, 32'h0}           // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hi;
        repeat (3) @(negedge clk);
        check("R1 reset_req", {31'b0, reset_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].addr, v);
                check($sformatf("table entry %0d", i), v, VEC[i].data);
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R4: frozen while disarmed, counting while bit 5 set
        wr(A_TMO, 32'h5A00_0005);
        tick(); tick();
        rd(A_TMO, v); check("R4 frozen when off", v, 32'h5);
        wr(A_CTRL, 32'h5A00_0030);
        tick(); tick();
        rd(A_TMO, v); check("R4 counts in mode 11", v, 32'h3);

        // R7: mode 11 runs to zero without reset
        hi = 0;
        for (int k = 0; k < 5; k++) begin tick(); if (reset_req) hi++; end
        rd(A_TMO, v); check("R7 count held at zero", v, 32'h0);
        check("R7 no reset request", hi, 0);

        // R6: stop freezes count and blocks reset
        wr(A_TMO, 32'h5A00_0002);
        wr(A_CTRL, 32'h5A00_0020);
        wr(A_CTRL, 32'h5A00_0102);
        hi = 0;
        for (int k = 0; k < 4; k++) begin tick(); if (reset_req) hi++; end
        rd(A_TMO, v); check("R6 count frozen", v, 32'h2);
        check("R6 no reset request", hi, 0);

        // R8: reload wins over a same-cycle tick
        wr(A_TMO, 32'h5A00_0005);
        wr(A_CTRL, 32'h5A00_0020);
        tick_en = 1'b1;
        wr(A_TMO, 32'h5A00_0007);
        tick_en = 1'b0;
        rd(A_TMO, v); check("R8 reload beats tick", v, 32'h7);

        // R8: reload wins over an expiring tick
        wr(A_TMO, 32'h5A00_0001);
        tick_en = 1'b1;
        wr(A_TMO, 32'h5A00_0009);
        tick_en = 1'b0;
        check("R8 no expiry on keepalive", {31'b0, reset_req}, 32'h0);
        rd(A_TMO, v); check("R8 keepalive value", v, 32'h9);

        // R5/R9: 10-tick expiry with halt hint in status
        wr(A_CTRL, 32'h5A00_0102);
        wr(A_STAT, 32'h5A00_0555);
        wr(A_TMO, 32'h5A00_000A);
        wr(A_CTRL, 32'h5A00_0020);
        for (int k = 0; k < 9; k++) tick();
        check("R5 no request before last tick", {31'b0, reset_req}, 32'h0);
        rd(A_TMO, v); check("R5 count at one", v, 32'h1);
        tick();
        hi = 0;
        while (reset_req && hi < 100) begin hi++; @(negedge clk); end
        check("R5 pulse width", hi, PULSE);
        rd(A_CTRL, v); check("R5 field cleared", v, 32'h0);
        rd(A_STAT, v); check("R9 cause bit with hint kept", v, 32'h575);

        // R5: armed with count already zero fires on next tick
        wr(A_TMO, 32'h5A00_0000);
        wr(A_CTRL, 32'h5A00_0020);
        tick();
        check("R5 fire at zero", {31'b0, reset_req}, 32'h1);
        repeat (PULSE + 1) @(negedge clk);

        // R10: power-on reset clears status
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_STAT, v); check("R10 status cleared", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule